// File: doc/BRIEF.md
# Power-Management Event Status and System Interrupt Generator

This block collects power-management events (a periodic timer rollover, a global-lock request, a power-button press and a real-time-clock alarm) into a status register. A matching enable register selects which of them may raise the system control interrupt. The interrupt output is a level: it stays high while at least one event is both pending and enabled. Software clears a pending event by writing a one to its status bit.

Software reaches the registers through a small I/O window of 64 bytes. The window can be moved anywhere in a 16-bit I/O space. Its base address comes from a configuration dword, with the six low address bits forced to zero, and a separate configuration bit switches the window on. The window also exposes a free-running power-management timer. The timer counts every clock, and each time its top bit changes it sets the timer event.

I/O requests are always accepted, and nothing at this interface can apply back-pressure. A read that decodes inside the enabled window returns its data one cycle later, together with a response-valid strobe that cannot be stalled. Accesses that miss the window get no response.

Top module: `pm_sci_gen`

## Requirements
- R1: After reset, every status bit, enable bit and the timer are zero, the window is disabled with base 0, and `sci`, `tmr_armed` and `io_rvalid` are low.
- R2: Configuration byte writes to addresses 0x40 and 0x41 load the low and high bytes of the window base. `win_base` shows that value ANDed with 0xFFC0. Writes to 0x42 and 0x43 have no effect on `win_base`.
- R3: Bit 0 of a configuration write to address 0x80 sets `win_en`. An I/O access decodes only when `win_en` is high and `io_addr[15:6]` equals `win_base[15:6]`. Any other access produces no `io_rvalid` and changes no register.
- R4: The status word sits at window offset 0. It holds the timer event at bit 0, global lock at bit 5, power button at bit 8 and RTC at bit 10, and all other bits read 0. Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged.
- R5: A one-cycle pulse on `evt_glbl`, `evt_pwrbtn` or `evt_rtc` sets its status bit. A set in the same cycle as a write-1-to-clear of that bit leaves the bit set.
- R6: The enable word sits at window offset 2. Only bits 0, 5, 8 and 10 are stored, and the other bits read 0.
- R7: The timer is a TMR_W-bit counter that increments on every clock from 0 after reset. Offset 8 reads its low 16 bits and offset 10 reads its upper bits, zero-extended. Writes to offsets 8 and 10 are ignored.
- R8: The timer status bit is set on the clock edge at which the timer's most significant bit changes, in either direction.
- R9: `sci` is high exactly when the status AND enable of the four event bits is nonzero. It follows the registers in the same cycle as they change.
- R10: `tmr_armed` is high exactly when the timer enable bit is set and the timer status bit is clear.
- R11: A read hit raises `io_rvalid` for one cycle on the next clock. `io_rdata` then holds the register value as it stood before that edge, and an unused offset inside the window reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| io_req | input | 1 | I/O access request, always accepted |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O byte address |
| io_wdata | input | 16 | I/O write data |
| io_rvalid | output | 1 | Read response valid, one cycle after a read hit |
| io_rdata | output | 16 | Read response data |
| evt_glbl | input | 1 | Global-lock event pulse |
| evt_pwrbtn | input | 1 | Power-button event pulse |
| evt_rtc | input | 1 | RTC alarm event pulse |
| sci | output | 1 | Level system control interrupt |
| tmr_armed | output | 1 | Timer event enabled and not yet pending |
| win_en | output | 1 | I/O window enabled |
| win_base | output | 16 | I/O window base address (64-byte aligned) |

## Verification
Directed sequences first raise events in isolation and then all together. Separate cases collide a status clear with a new event on the same bit, which separates the set-wins rule from plain write-1-to-clear. The timer is run through both directions of its top-bit change, which shows whether status is raised on each rollover or only on one edge. Writes and reads are also aimed at a disabled window and at a relocated base, which shows that decode depends on both the enable bit and the masked base.

A seeded random phase then mixes event pulses, reads and writes to every window offset, out-of-window accesses and occasional configuration writes. Each cycle, `sci`, `tmr_armed` and every read response are compared against a reference model built from the requirements.

// File: rtl/pm_sci_pkg.sv
package pm_sci_pkg;

  localparam int STS_TMR = 0;
  localparam int STS_GBL = 5;
  localparam int STS_PWR = 8;
  localparam int STS_RTC = 10;

  localparam logic [15:0] EVT_MASK = (16'h1 << STS_TMR) | (16'h1 << STS_GBL) |
                                     (16'h1 << STS_PWR) | (16'h1 << STS_RTC);

  localparam logic [5:0] OFS_STS    = 6'h00;
  localparam logic [5:0] OFS_EN     = 6'h02;
  localparam logic [5:0] OFS_TMR_LO = 6'h08;
  localparam logic [5:0] OFS_TMR_HI = 6'h0A;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STS,
    SEL_EN,
    SEL_TLO,
    SEL_THI
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [5:0] ofs);
    case (ofs)
      OFS_STS:    return SEL_STS;
      OFS_EN:     return SEL_EN;
      OFS_TMR_LO: return SEL_TLO;
      OFS_TMR_HI: return SEL_THI;
      default:    return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs #(
  parameter int CFG_AW = 8,
  parameter logic [CFG_AW-1:0] BASE_OFS = 8'h40,
  parameter logic [CFG_AW-1:0] EN_OFS = 8'h80,
  parameter int IO_AW = 16,
  parameter int WIN_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [IO_AW-1:0]  win_base_o,
  output logic              win_en_o
);

  localparam int NBYTES = (IO_AW + 7) / 8;
  localparam logic [IO_AW-1:0] LOW_MASK = IO_AW'((1 << WIN_AW) - 1);

  logic [NBYTES*8-1:0] base_q;
  logic                en_q;

  for (genvar b = 0; b < NBYTES; b++) begin : g_base_byte
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[8*b +: 8] <= '0;
      end else if (cfg_we && (cfg_addr == (BASE_OFS + CFG_AW'(b)))) begin
        base_q[8*b +: 8] <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (cfg_we && (cfg_addr == EN_OFS)) begin
      en_q <= cfg_wdata[0];
    end
  end

  assign win_base_o = base_q[IO_AW-1:0] & ~LOW_MASK;
  assign win_en_o   = en_q;

  // R2
  base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_base_o & LOW_MASK) == '0);

  // R3
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && (cfg_addr == EN_OFS)) |=> $stable(win_en_o));

endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [TMR_W-1:0] cnt_o,
  output logic             msb_flip_o
);

  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o      = cnt_q;
  assign msb_flip_o = &cnt_q[TMR_W-2:0];

  // R7
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_sci_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] set_vec,
  input  logic [15:0] clr_vec,
  input  logic        en_we,
  input  logic [15:0] en_wdata,
  output logic [15:0] sts_o,
  output logic [15:0] en_o,
  output logic        sci_o
);

  logic [15:0] sts_q;
  logic [15:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else begin
      sts_q <= ((sts_q & ~clr_vec) | set_vec) & EVT_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_wdata & EVT_MASK;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign sci_o = |(sts_q & en_q);

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((sts_q & $past(set_vec & EVT_MASK)) == $past(set_vec & EVT_MASK)));

  // R4
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((sts_q & $past(clr_vec & ~set_vec)) == '0));

  // R9
  sci_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !sci_o);

endmodule

// File: rtl/pm_sci_gen.sv
module pm_sci_gen
  import pm_sci_pkg::*;
#(
  parameter int TMR_W = 24,
  parameter int IO_AW = 16,
  parameter int WIN_BYTES = 64,
  parameter int CFG_AW = 8,
  parameter logic [CFG_AW-1:0] CFG_BASE_OFS = 8'h40,
  parameter logic [CFG_AW-1:0] CFG_EN_OFS = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              io_req,
  input  logic              io_we,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [15:0]       io_wdata,
  output logic              io_rvalid,
  output logic [15:0]       io_rdata,
  input  logic              evt_glbl,
  input  logic              evt_pwrbtn,
  input  logic              evt_rtc,
  output logic              sci,
  output logic              tmr_armed,
  output logic              win_en,
  output logic [IO_AW-1:0]  win_base
);

  localparam int WIN_AW = $clog2(WIN_BYTES);

  logic [TMR_W-1:0] tmr_cnt;
  logic             tmr_flip;
  logic [15:0]      sts, en;
  logic             hit;
  reg_sel_e         sel;
  logic [15:0]      set_vec, clr_vec;
  logic             en_we;
  logic [31:0]      tmr_wide;
  logic [15:0]      rd_mux;

  pm_cfg_regs #(
    .CFG_AW(CFG_AW), .BASE_OFS(CFG_BASE_OFS), .EN_OFS(CFG_EN_OFS),
    .IO_AW(IO_AW), .WIN_AW(WIN_AW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .win_base_o(win_base), .win_en_o(win_en)
  );

  pm_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .cnt_o(tmr_cnt), .msb_flip_o(tmr_flip)
  );

  assign hit = win_en && (io_addr[IO_AW-1:WIN_AW] == win_base[IO_AW-1:WIN_AW]);
  assign sel = decode_ofs(6'(io_addr[WIN_AW-1:0]));

  always_comb begin
    set_vec          = '0;
    set_vec[STS_TMR] = tmr_flip;
    set_vec[STS_GBL] = evt_glbl;
    set_vec[STS_PWR] = evt_pwrbtn;
    set_vec[STS_RTC] = evt_rtc;
  end

  assign clr_vec = (io_req && io_we && hit && (sel == SEL_STS)) ? io_wdata : '0;
  assign en_we   = io_req && io_we && hit && (sel == SEL_EN);

  pm_evt_regs u_evt (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .en_we(en_we), .en_wdata(io_wdata), .sts_o(sts), .en_o(en), .sci_o(sci)
  );

  assign tmr_armed = en[STS_TMR] && !sts[STS_TMR];
  assign tmr_wide  = 32'(tmr_cnt);

  always_comb begin
    case (sel)
      SEL_STS: rd_mux = sts;
      SEL_EN:  rd_mux = en;
      SEL_TLO: rd_mux = tmr_wide[15:0];
      SEL_THI: rd_mux = tmr_wide[31:16];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
    end else begin
      io_rvalid <= io_req && !io_we && hit;
      if (io_req && !io_we && hit) io_rdata <= rd_mux;
    end
  end

  // R3
  miss_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && !hit) |=> !io_rvalid);

  // R11
  read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && !io_we && hit) |=> io_rvalid);

  // R8
  msb_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_cnt[TMR_W-1] != $past(tmr_cnt[TMR_W-1])) |-> sts[STS_TMR]);

  // R10
  armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_armed |-> !sts[STS_TMR]);

endmodule

// File: tb/test_pm_sci_gen.sv
module test_pm_sci_gen;

  localparam int TW = 10;
  localparam logic [15:0] MASK = 16'h0521;
  localparam logic [15:0] WB = 16'hC340;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_we = 0;
  logic [7:0]  cfg_addr = 0, cfg_wdata = 0;
  logic        io_req = 0, io_we = 0;
  logic [15:0] io_addr = 0, io_wdata = 0;
  logic        evt_glbl = 0, evt_pwrbtn = 0, evt_rtc = 0;
  logic        io_rvalid, sci, tmr_armed, win_en;
  logic [15:0] io_rdata, win_base;

  pm_sci_gen #(.TMR_W(TW)) i_pm_sci_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .io_req(io_req), .io_we(io_we), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
    .evt_glbl(evt_glbl), .evt_pwrbtn(evt_pwrbtn), .evt_rtc(evt_rtc),
    .sci(sci), .tmr_armed(tmr_armed), .win_en(win_en), .win_base(win_base)
  );

  int checks = 0;
  int errors = 0;
  bit chk_on = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference model built from the requirements
  logic [TW-1:0] m_cnt;
  logic [15:0]   m_sts, m_en, m_base, m_rd;
  logic          m_wen, m_rv;

  function automatic logic m_hit(input logic [15:0] a, input logic [15:0] base, input logic wen);
    return wen && (a[15:6] == base[15:6]);
  endfunction

  function automatic logic [15:0] m_read(input logic [5:0] ofs, input logic [15:0] s,
                                         input logic [15:0] e, input logic [TW-1:0] c);
    logic [31:0] w;
    w = 32'(c);
    case (ofs)
      6'h00:   return s;
      6'h02:   return e;
      6'h08:   return w[15:0];
      6'h0A:   return w[31:16];
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [TW-1:0] nx;
    logic [15:0]   setv, clrv;
    logic          h;
    if (!rst_n) begin
      m_cnt <= '0; m_sts <= '0; m_en <= '0; m_base <= '0;
      m_wen <= 1'b0; m_rv <= 1'b0; m_rd <= '0;
    end else begin
      nx = m_cnt + 1'b1;
      setv = '0;
      setv[0]  = (nx[TW-1] != m_cnt[TW-1]);
      setv[5]  = evt_glbl;
      setv[8]  = evt_pwrbtn;
      setv[10] = evt_rtc;
      h = io_req && m_hit(io_addr, m_base, m_wen);
      clrv = (h && io_we && io_addr[5:0] == 6'h00) ? io_wdata : 16'h0;
      m_sts <= ((m_sts & ~clrv) | setv) & MASK;
      if (h && io_we && io_addr[5:0] == 6'h02) m_en <= io_wdata & MASK;
      if (cfg_we) begin
        if (cfg_addr == 8'h40) m_base[7:0]  <= cfg_wdata;
        if (cfg_addr == 8'h41) m_base[15:8] <= cfg_wdata;
        if (cfg_addr == 8'h80) m_wen <= cfg_wdata[0];
      end
      m_rv <= h && !io_we;
      if (h && !io_we) m_rd <= m_read(io_addr[5:0], m_sts, m_en, m_cnt);
      m_cnt <= nx;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R9 sci level", sci, |(m_sts & m_en));
      chk("R10 tmr_armed", tmr_armed, m_en[0] & ~m_sts[0]);
      chk("R11 rvalid", io_rvalid, m_rv);
      if (m_rv) chk("R11 rdata", io_rdata, m_rd);
      chk("R2 win_base", win_base, m_base & 16'hFFC0);
      chk("R3 win_en", win_en, m_wen);
    end
  end

  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); io_req = 1; io_we = 1; io_addr = a; io_wdata = d;
    @(negedge clk); io_req = 0; io_we = 0;
  endtask

  task automatic io_rd(input logic [15:0] a, output logic [15:0] d, output logic v);
    @(negedge clk); io_req = 1; io_we = 0; io_addr = a;
    @(negedge clk); io_req = 0; d = io_rdata; v = io_rvalid;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] d, t1, t2;
    logic v;
    int seed;
    seed = $urandom(32'h5EED1);
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sci", sci, 0);
    chk("R1 tmr_armed", tmr_armed, 0);
    chk("R1 rvalid", io_rvalid, 0);
    chk("R1 win_en", win_en, 0);
    chk("R1 win_base", win_base, 0);
    chk_on = 1;

    // R3 window disabled: no response
    io_rd(16'h0000, d, v);
    chk("R3 disabled read no response", v, 0);

    // R2 base programming
    cfg_wr(8'h40, 8'h41);
    cfg_wr(8'h41, 8'hC3);
    cfg_wr(8'h42, 8'h12);
    cfg_wr(8'h43, 8'h34);
    cfg_wr(8'h80, 8'h01);
    @(negedge clk);
    chk("R2 base masked", win_base, WB);
    chk("R3 enabled", win_en, 1);

    // R4/R5 events set status
    @(negedge clk); evt_glbl = 1; evt_pwrbtn = 1; evt_rtc = 1;
    @(negedge clk); evt_glbl = 0; evt_pwrbtn = 0; evt_rtc = 0;
    io_rd(WB, d, v);
    chk("R11 read hit valid", v, 1);
    chk("R5 events set", d & 16'h0520, 16'h0520);
    chk("R4 unimplemented bits zero", d & ~MASK, 0);

    // R4 write-1-to-clear of one bit
    io_wr(WB, 16'h0020);
    io_rd(WB, d, v);
    chk("R4 w1c cleared bit5", d & 16'h0520, 16'h0500);

    // R5 set wins over simultaneous clear
    @(negedge clk); io_req = 1; io_we = 1; io_addr = WB; io_wdata = 16'h0100; evt_pwrbtn = 1;
    @(negedge clk); io_req = 0; io_we = 0; evt_pwrbtn = 0;
    io_rd(WB, d, v);
    chk("R5 set beats clear", d[8], 1);
    io_wr(WB, 16'h0500);
    io_rd(WB, d, v);
    chk("R4 w1c pair", d & 16'h0500, 16'h0000);

    // R6 enable storage
    io_wr(WB + 16'd2, 16'hFFFF);
    io_rd(WB + 16'd2, d, v);
    chk("R6 enable masked", d, MASK);
    io_wr(WB + 16'd2, 16'h0000);

    // R9 interrupt level follows one enabled event
    io_wr(WB + 16'd2, 16'h0100);
    @(negedge clk); evt_pwrbtn = 1;
    @(negedge clk); evt_pwrbtn = 0;
    chk("R9 sci raised", sci, 1);
    io_wr(WB, 16'h0100);
    chk("R9 sci dropped", sci, 0);

    // R7 timer runs and ignores writes
    io_rd(WB + 16'd8, t1, v);
    io_rd(WB + 16'd8, t2, v);
    chk("R7 timer step", (t2 - t1) & 16'h03FF, 2);
    io_rd(WB + 16'd8, t1, v);
    io_wr(WB + 16'd8, 16'hFFFF);
    io_rd(WB + 16'd8, t2, v);
    chk("R7 timer write ignored", (t2 - t1) & 16'h03FF, 4);
    io_rd(WB + 16'd10, d, v);
    chk("R7 upper word zero", d, 0);
    io_rd(WB + 16'd4, d, v);
    chk("R11 unused offset", d, 0);

    // R8/R10 timer event on both MSB directions
    io_wr(WB + 16'd2, 16'h0001);
    io_wr(WB, 16'h0001);
    chk("R10 armed after clear", tmr_armed, 1);
    for (int k = 0; k < 2; k++) begin
      while (!sci) @(negedge clk);
      chk("R10 disarmed when pending", tmr_armed, 0);
      io_rd(WB + 16'd8, d, v);
      chk("R8 event at msb change", d & 16'h01FF, 1);
      io_wr(WB, 16'h0001);
    end
    io_wr(WB + 16'd2, 16'h0000);

    // R3 disabled window ignores accesses
    @(negedge clk); evt_rtc = 1;
    @(negedge clk); evt_rtc = 0;
    io_wr(WB + 16'd2, 16'h0400);
    cfg_wr(8'h80, 8'h00);
    io_wr(WB, 16'hFFFF);
    io_wr(WB + 16'd2, 16'h0000);
    io_rd(WB, d, v);
    chk("R3 disabled no response", v, 0);
    cfg_wr(8'h80, 8'h01);
    io_rd(WB, d, v);
    chk("R3 status untouched", d[10], 1);
    io_rd(WB + 16'd2, d, v);
    chk("R3 enable untouched", d, 16'h0400);
    chk("R9 sci from rtc", sci, 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int k;
      @(negedge clk);
      evt_glbl   = ($urandom % 8) == 0;
      evt_pwrbtn = ($urandom % 8) == 0;
      evt_rtc    = ($urandom % 8) == 0;
      io_req   = ($urandom % 3) == 0;
      io_we    = $urandom % 2;
      io_wdata = 16'($urandom);
      k = $urandom % 6;
      case (k)
        0: io_addr = (m_base & 16'hFFC0);
        1: io_addr = (m_base & 16'hFFC0) + 16'd2;
        2: io_addr = (m_base & 16'hFFC0) + 16'd8;
        3: io_addr = (m_base & 16'hFFC0) + 16'd10;
        4: io_addr = (m_base & 16'hFFC0) + 16'($urandom % 64);
        default: io_addr = 16'($urandom);
      endcase
      cfg_we = ($urandom % 50) == 0;
      k = $urandom % 4;
      cfg_addr  = (k == 0) ? 8'h40 : (k == 1) ? 8'h41 : (k == 2) ? 8'h80 : 8'h81;
      cfg_wdata = 8'($urandom);
      if (cfg_addr == 8'h80 && ($urandom % 4) != 0) cfg_wdata[0] = 1'b1;
    end
    @(negedge clk);
    io_req = 0; io_we = 0; cfg_we = 0;
    evt_glbl = 0; evt_pwrbtn = 0; evt_rtc = 0;
    repeat (3) @(negedge clk);
    summary();
  end

endmodule